// File: doc/BRIEF.md
# Run-of-Three Serial Equality Detector

This block watches a serial bit stream, one bit per clock. Its output `match` is raised in the same cycle that the incoming bit makes a run of three or more identical consecutive bits, or makes such a run longer. Runs of ones and runs of zeros count alike. The output is of Mealy type: it is formed from the stored state and the present input bit, so it answers within the cycle and has no register delay.

After reset the machine sits in an idle state that remembers no bits. Four further states record which value the previous bit had and whether the run so far is one bit long or two or more bits long. The transitions are as follows:

- `S_IDLE`: a 0 leads to `S_ZERO_ONE` and a 1 leads to `S_ONE_ONE`.
- `S_ZERO_ONE`: a 0 leads to `S_ZERO_MANY` and a 1 leads to `S_ONE_ONE`.
- `S_ZERO_MANY`: a 0 stays in `S_ZERO_MANY` and raises `match`. A 1 leads to `S_ONE_ONE`.
- `S_ONE_ONE`: a 1 leads to `S_ONE_MANY` and a 0 leads to `S_ZERO_ONE`.
- `S_ONE_MANY`: a 1 stays in `S_ONE_MANY` and raises `match`. A 0 leads to `S_ZERO_ONE`.

A debug port shows the state code.

Top module: `run3_detector`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_dbg` reads 0 (`S_IDLE`) after that edge.
- R2: While `rst` is high, `match` is 0.
- R3: `match` is 0 unless the current bit and the two bits accepted just before it, all since the last reset, are equal. In particular, the first two bits after reset never raise it.
- R4: When `din`=1 and the two bits accepted just before it were both 1, `match` is 1 in that same cycle.
- R5: When `din`=0 and the two bits accepted just before it were both 0, `match` is 1 in that same cycle.
- R6: Once a run has reached three bits, `match` stays 1 in every cycle the run goes on.
- R7: A bit that differs from the previous bit gives `match`=0 and starts a new run of length one. The state becomes code 1 after a 0 and code 3 after a 1.
- R8: The `state_dbg` codes are fixed:
  - 0: idle
  - 1: last bit 0, run of one
  - 2: last bit 0, run of two or more
  - 3: last bit 1, run of one
  - 4: last bit 1, run of two or more

  No other code ever appears.
- R9: A reset in the middle of a run discards that run. The next two equal bits give `match`=0, and the third gives `match`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| match | output | 1 | Mealy run-of-three indication |
| state_dbg | output | 3 | Current state code |

## Verification
The hardest case to reach from the ports is an unbroken run that continues well past three bits and then flips polarity right after a reset or right after a run of one. This is where a machine that saturates at the wrong count, or keeps history across a reset, goes wrong.

The stimulus uses three parts:
- every 6-bit pattern, each one following a fresh reset;
- a long random stream whose bits flip with low probability, which produces long runs of both polarities;
- a directed reset dropped into the middle of a ones run.

// File: rtl/run3_pkg.sv
package run3_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        S_IDLE      = 3'd0,
        S_ZERO_ONE  = 3'd1,
        S_ZERO_MANY = 3'd2,
        S_ONE_ONE   = 3'd3,
        S_ONE_MANY  = 3'd4
    } run_state_e;
endpackage

// File: rtl/run3_next.sv
module run3_next
    import run3_pkg::*;
(
    input  run_state_e cur,
    input  logic       bit_in,
    output run_state_e nxt
);
    always_comb begin
        unique case (cur)
            S_IDLE:      nxt = bit_in ? S_ONE_ONE  : S_ZERO_ONE;
            S_ZERO_ONE:  nxt = bit_in ? S_ONE_ONE  : S_ZERO_MANY;
            S_ZERO_MANY: nxt = bit_in ? S_ONE_ONE  : S_ZERO_MANY;
            S_ONE_ONE:   nxt = bit_in ? S_ONE_MANY : S_ZERO_ONE;
            S_ONE_MANY:  nxt = bit_in ? S_ONE_MANY : S_ZERO_ONE;
            default:     nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/run3_out.sv
module run3_out
    import run3_pkg::*;
(
    input  run_state_e cur,
    input  logic       bit_in,
    input  logic       hold,
    output logic       hit
);
    always_comb begin
        hit = 1'b0;
        if (!hold) begin
            unique case (cur)
                S_ZERO_MANY: hit = ~bit_in;
                S_ONE_MANY:  hit = bit_in;
                S_IDLE, S_ZERO_ONE, S_ONE_ONE: hit = 1'b0;
                default:     hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/run3_detector.sv
module run3_detector
    import run3_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output logic                match,
    output logic [STATE_W-1:0]  state_dbg
);
    run_state_e state_q;
    run_state_e state_d;

    run3_next u_next (
        .cur    (state_q),
        .bit_in (din),
        .nxt    (state_d)
    );

    run3_out u_out (
        .cur    (state_q),
        .bit_in (din),
        .hold   (rst),
        .hit    (match)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign state_dbg = state_q;
endmodule

// File: rtl/run3_checker.sv
module run3_checker (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       match,
    input logic [2:0] state_dbg
);
    logic       rst_q;
    logic       seen;
    logic       last;
    logic [1:0] len;

    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            last <= 1'b0;
            len  <= 2'd0;
        end else if (!seen || din != last) begin
            seen <= 1'b1;
            last <= din;
            len  <= 2'd1;
        end else if (len != 2'd2) begin
            len <= len + 2'd1;
        end
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1)
            p_idle_after_reset_r1: assert (state_dbg == 3'd0) else $error("state not idle after reset");
        if (rst === 1'b1)
            p_quiet_in_reset_r2: assert (match == 1'b0) else $error("match during reset");
    end

    p_no_early_match_r3: assert property (@(posedge clk) disable iff (rst)
        !(seen && len == 2'd2 && din == last) |-> !match);

    p_ones_run_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && last && din && len == 2'd2) |-> match);

    p_zeros_run_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && !last && !din && len == 2'd2) |-> match);

    p_flip_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(din) |-> !match);

    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        state_dbg <= 3'd4);
endmodule

bind run3_detector run3_checker u_run3_checker (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .match     (match),
    .state_dbg (state_dbg)
);

// File: tb/test_run3_detector.sv
`timescale 1ns/1ps
module test_run3_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       match;
    logic [2:0] state_dbg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic       exp_match;
        logic [2:0] exp_st;
        bit         chk_st;
        string      tag;
    } item_t;

    item_t q[$];

    // behavioural run-length model
    bit m_known = 1'b0;
    bit m_valid = 1'b0;
    bit m_last  = 1'b0;
    int m_cnt   = 0;

    always #4 clk = ~clk;

    run3_detector i_run3_detector (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .match     (match),
        .state_dbg (state_dbg)
    );

    function automatic logic [2:0] model_state();
        if (!m_valid) return 3'd0;
        if (!m_last)  return (m_cnt >= 2) ? 3'd2 : 3'd1;
        return (m_cnt >= 2) ? 3'd4 : 3'd3;
    endfunction

    task automatic drive_bit(input logic b, input logic r, input string ovr);
        item_t it;
        @(negedge clk);
        rst = r;
        din = b;
        it.exp_match = !r && m_valid && (b == m_last) && (m_cnt >= 2);
        it.exp_st    = model_state();
        it.chk_st    = m_known;
        if (r)                                   it.tag = "R2";
        else if (it.exp_match && m_cnt >= 3)     it.tag = "R6";
        else if (it.exp_match)                   it.tag = b ? "R4" : "R5";
        else if (m_valid && b != m_last)         it.tag = "R7";
        else                                     it.tag = "R3";
        if (ovr != "") it.tag = ovr;
        q.push_back(it);
        if (r) begin
            m_known = 1'b1;
            m_valid = 1'b0;
            m_cnt   = 0;
        end else if (!m_valid || b != m_last) begin
            m_valid = 1'b1;
            m_last  = b;
            m_cnt   = 1;
        end else if (m_cnt < 3) begin
            m_cnt = m_cnt + 1;
        end
    endtask

    // monitor: pops one expected item per cycle, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (match !== it.exp_match) begin
                    n_bad++;
                    $display("FAIL %s match: actual %b expected %b", it.tag, match, it.exp_match);
                end
                if (it.chk_st) begin
                    n_cmp++;
                    if (state_dbg !== it.exp_st) begin
                        n_bad++;
                        $display("FAIL R8 (R1 after reset) state: actual %0d expected %0d",
                                 state_dbg, it.exp_st);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic cur;
        // R1 / R2: reset state
        drive_bit(1'b1, 1'b1, "R2");
        drive_bit(1'b0, 1'b1, "R2");
        // exhaustive 6-bit patterns after a fresh reset (R3, R4, R5, R7)
        for (int s = 0; s < 64; s++) begin
            drive_bit(1'b0, 1'b1, "");
            for (int k = 0; k < 6; k++) drive_bit(s[k], 1'b0, "");
        end
        // R6: long runs of each polarity
        drive_bit(1'b0, 1'b1, "");
        for (int k = 0; k < 9; k++) drive_bit(1'b1, 1'b0, "");
        for (int k = 0; k < 9; k++) drive_bit(1'b0, 1'b0, "");
        // R9: reset in the middle of a ones run
        for (int k = 0; k < 4; k++) drive_bit(1'b1, 1'b0, "");
        drive_bit(1'b1, 1'b1, "R9");
        drive_bit(1'b1, 1'b0, "R9");
        drive_bit(1'b1, 1'b0, "R9");
        drive_bit(1'b1, 1'b0, "R9");
        // random stream with rare flips
        cur = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom % 4 == 0) cur = ~cur;
            drive_bit(cur, ($urandom % 500) == 0, "");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule